// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt lines, latches a rising edge on each into a request register, and raises one interrupt output whenever an unmasked request outranks everything currently being serviced. Software programs the block through a byte-wide port with two addresses, even and odd. A fixed series of configuration words sets the vector base, the cascade wiring and the end-of-interrupt style. After that, the odd address holds the mask register. The even address takes commands: the two end-of-interrupt forms and the choice of which status register it reads back.

A processor-side acknowledge pulse answers the interrupt output. In the same cycle the block drives an 8-bit vector built from the programmed base and the winning level. At the next clock edge the winning request moves from the request register to the in-service register. In automatic end-of-interrupt mode it is dropped instead. An acknowledge with no eligible request is spurious: it returns the level-7 vector and changes neither register. The cascade word is stored as written, and its low three bits are presented as a slave identity.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask register reads 0xFF, the even-address readback selects the request register, the request and in-service registers are zero, and `int_out` is low.
- R2: An even-address write with bit 4 set starts configuration. It clears the request and in-service registers, turns automatic EOI off and returns the readback selection to the request register. The following odd-address writes are taken as the vector base, then the cascade word (skipped when bit 1 of the start word is 1), then the mode word (expected only when bit 0 of the start word is 1). `int_out` stays low until the last expected word has been written.
- R3: The cascade word is stored whole on `slave_map`, and its bits 2:0 appear on `slave_id`. A configuration that skips the cascade word leaves the stored value unchanged.
- R4: Outside configuration, an odd-address write loads the mask register, where bit n = 1 masks line n. An odd-address read returns the mask.
- R5: A 0-to-1 transition on line n sets request bit n whether or not that line is masked. A line that stays high sets nothing more.
- R6: Level 0 is the most urgent. `int_out` is high when an unmasked request exists whose level is lower in number than every set in-service bit, or when no in-service bit is set.
- R7: On an acknowledge while `int_out` is high, `ack_vector` in that cycle equals base bits 7:3 followed by the winning level in bits 2:0. At the next edge that request bit clears and the matching in-service bit sets.
- R8: An acknowledge while `int_out` is low (spurious) returns base bits 7:3 followed by 3'b111, even when line 7 is masked, and changes no in-service bit.
- R9: Writing 0x0A to the even address makes even-address reads return the request register. Writing 0x0B makes them return the in-service register. The choice persists across other writes.
- R10: Writing 0x60 + n to the even address clears in-service bit n only. The other in-service bits keep their values.
- R11: Writing 0x20 to the even address clears the most urgent set in-service bit.
- R12: A mode word with bit 1 set (0x03) selects automatic EOI. An acknowledge then clears the request bit but sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr_odd | input | 1 | 0 selects the even address, 1 selects the odd address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Readback of the selected register, combinational from `addr_odd` |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| ack | input | 1 | Acknowledge pulse, one cycle |
| ack_vector | output | 8 | Vector returned during the acknowledge cycle |
| int_out | output | 1 | Interrupt request to the processor |
| slave_id | output | 3 | Low three bits of the stored cascade word |
| slave_map | output | 8 | Stored cascade word |

## Verification
The embedded assertions check the following on every cycle:
- reset leaves the mask all ones;
- the output stays low while the block is unconfigured;
- the resolved level really is the most urgent eligible one;
- a taken acknowledge sets its in-service bit;
- a spurious or automatic-EOI acknowledge leaves the in-service register alone;
- a specific EOI clears its bit.

Some behaviour only the bench's scenarios can show:
- vector values built from the programmed base;
- nesting, where a more urgent line interrupts one already in service;
- which bit a non-specific EOI clears;
- a skipped cascade word keeping the old value;
- ignoring a held-high line after configuration clears the request register.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_READY,
        PH_BASE,
        PH_CASC,
        PH_MODE
    } cfg_phase_e;

    typedef enum logic {
        RB_REQ,
        RB_SVC
    } rb_sel_e;

    typedef struct packed {
        logic       start;
        logic       want_casc;
        logic       want_mode;
        logic       sel_req;
        logic       sel_svc;
        logic       eoi_spec;
        logic       eoi_any;
        logic [2:0] eoi_lvl;
    } even_cmd_t;

    function automatic even_cmd_t decode_even(input byte_t w);
        even_cmd_t c;
        c           = '0;
        c.start     = w[4];
        c.want_casc = !w[1];
        c.want_mode = w[0];
        if (!w[4]) begin
            if (w[3]) begin
                c.sel_req = (w[1:0] == 2'b10);
                c.sel_svc = (w[1:0] == 2'b11);
            end else begin
                c.eoi_spec = (w[7:5] == 3'b011);
                c.eoi_any  = (w[7:5] == 3'b001);
                c.eoi_lvl  = w[2:0];
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/intc_prog.sv
module intc_prog
    import prio_intc_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int LVL_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                addr_odd,
    input  byte_t               wr_data,
    output logic [N_IRQ-1:0]    mask_o,
    output logic [BYTE_W-1:LVL_W] base_o,
    output byte_t               casc_o,
    output logic                aeoi_o,
    output rb_sel_e             rb_sel_o,
    output logic                ready_o,
    output logic                clr_all_o,
    output logic                eoi_spec_o,
    output logic                eoi_any_o,
    output logic [LVL_W-1:0]    eoi_lvl_o
);

    cfg_phase_e            phase_q;
    logic                  want_casc_q, want_mode_q;
    logic [N_IRQ-1:0]      mask_q;
    logic [BYTE_W-1:LVL_W] base_q;
    byte_t                 casc_q;
    logic                  aeoi_q, ready_q;
    rb_sel_e               rb_q;
    even_cmd_t             cmd;
    logic                  even_wr;

    assign cmd     = decode_even(wr_data);
    assign even_wr = wr_en && !addr_odd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_READY;
            want_casc_q <= 1'b0;
            want_mode_q <= 1'b0;
            mask_q      <= '1;
            base_q      <= '0;
            casc_q      <= '0;
            aeoi_q      <= 1'b0;
            ready_q     <= 1'b0;
            rb_q        <= RB_REQ;
        end else if (even_wr) begin
            if (cmd.start) begin
                phase_q     <= PH_BASE;
                want_casc_q <= cmd.want_casc;
                want_mode_q <= cmd.want_mode;
                aeoi_q      <= 1'b0;
                ready_q     <= 1'b0;
                rb_q        <= RB_REQ;
            end else if (cmd.sel_req) begin
                rb_q <= RB_REQ;
            end else if (cmd.sel_svc) begin
                rb_q <= RB_SVC;
            end
        end else if (wr_en) begin
            unique case (phase_q)
                PH_READY: mask_q <= wr_data[N_IRQ-1:0];
                PH_BASE: begin
                    base_q <= wr_data[BYTE_W-1:LVL_W];
                    if (want_casc_q) begin
                        phase_q <= PH_CASC;
                    end else if (want_mode_q) begin
                        phase_q <= PH_MODE;
                    end else begin
                        phase_q <= PH_READY;
                        ready_q <= 1'b1;
                    end
                end
                PH_CASC: begin
                    casc_q <= wr_data;
                    if (want_mode_q) begin
                        phase_q <= PH_MODE;
                    end else begin
                        phase_q <= PH_READY;
                        ready_q <= 1'b1;
                    end
                end
                PH_MODE: begin
                    aeoi_q  <= wr_data[1];
                    phase_q <= PH_READY;
                    ready_q <= 1'b1;
                end
                default: phase_q <= PH_READY;
            endcase
        end
    end

    assign mask_o     = mask_q;
    assign base_o     = base_q;
    assign casc_o     = casc_q;
    assign aeoi_o     = aeoi_q;
    assign rb_sel_o   = rb_q;
    assign ready_o    = ready_q;
    assign clr_all_o  = even_wr && cmd.start;
    assign eoi_spec_o = even_wr && cmd.eoi_spec;
    assign eoi_any_o  = even_wr && cmd.eoi_any;
    assign eoi_lvl_o  = cmd.eoi_lvl[LVL_W-1:0];

    AST_RST_MASK_ALL: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && !ready_q && rb_q == RB_REQ)); // R1
    AST_READY_FROM_ODD: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> $past(wr_en && addr_odd)); // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_odd && phase_q == PH_READY) |=> mask_q == $past(wr_data[N_IRQ-1:0])); // R4

endmodule

// File: rtl/intc_resolve.sv
module intc_resolve #(
    parameter int N_IRQ = 8,
    parameter int LVL_W = 3
) (
    input  logic [N_IRQ-1:0] irr_i,
    input  logic [N_IRQ-1:0] isr_i,
    input  logic [N_IRQ-1:0] mask_i,
    output logic             pend_valid_o,
    output logic [LVL_W-1:0] pend_lvl_o,
    output logic             svc_any_o,
    output logic [LVL_W-1:0] svc_top_o,
    output logic             raise_o
);

    logic [N_IRQ-1:0] elig;

    assign elig = irr_i & ~mask_i;

    always_comb begin
        pend_valid_o = 1'b0;
        pend_lvl_o   = '0;
        svc_any_o    = 1'b0;
        svc_top_o    = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pend_valid_o = 1'b1;
                pend_lvl_o   = LVL_W'(i);
            end
            if (isr_i[i]) begin
                svc_any_o = 1'b1;
                svc_top_o = LVL_W'(i);
            end
        end
        raise_o = pend_valid_o && (!svc_any_o || pend_lvl_o < svc_top_o);
    end

    always_comb begin
        if (pend_valid_o) begin
            AST_PICK_MOST_URGENT: assert ((elig & ((N_IRQ'(1) << pend_lvl_o) - N_IRQ'(1))) == '0
                                          && elig[pend_lvl_o]); // R6
        end
    end

endmodule

// File: rtl/intc_track.sv
module intc_track #(
    parameter int N_IRQ = 8,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             clr_all_i,
    input  logic             ack_i,
    input  logic             take_i,
    input  logic [LVL_W-1:0] take_lvl_i,
    input  logic             aeoi_i,
    input  logic             eoi_spec_i,
    input  logic             eoi_any_i,
    input  logic [LVL_W-1:0] eoi_lvl_i,
    input  logic             svc_any_i,
    input  logic [LVL_W-1:0] svc_top_i,
    output logic [N_IRQ-1:0] irr_o,
    output logic [N_IRQ-1:0] isr_o
);

    logic [N_IRQ-1:0] irq_prev_q, irr_q, isr_q;
    logic [N_IRQ-1:0] rise, take_bit, eoi_bit;

    assign rise     = irq_i & ~irq_prev_q;
    assign take_bit = take_i ? (N_IRQ'(1) << take_lvl_i) : '0;

    always_comb begin
        eoi_bit = '0;
        if (eoi_spec_i) begin
            eoi_bit = N_IRQ'(1) << eoi_lvl_i;
        end else if (eoi_any_i && svc_any_i) begin
            eoi_bit = N_IRQ'(1) << svc_top_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_prev_q <= '0;
            irr_q      <= '0;
            isr_q      <= '0;
        end else begin
            irq_prev_q <= irq_i;
            if (clr_all_i) begin
                irr_q <= '0;
                isr_q <= '0;
            end else begin
                irr_q <= (irr_q & ~take_bit) | rise;
                isr_q <= (isr_q & ~eoi_bit) | (aeoi_i ? '0 : take_bit);
            end
        end
    end

    assign irr_o = irr_q;
    assign isr_o = isr_q;

    AST_TAKE_SETS_SVC: assert property (@(posedge clk) disable iff (rst)
        (take_i && !aeoi_i && !clr_all_i) |=> isr_q[$past(take_lvl_i)]); // R7
    AST_SPUR_SVC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !take_i && !clr_all_i && !eoi_spec_i && !eoi_any_i) |=> $stable(isr_q)); // R8
    AST_AUTO_EOI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (take_i && aeoi_i && !clr_all_i && !eoi_spec_i && !eoi_any_i) |=> $stable(isr_q)); // R12
    AST_SPEC_EOI_CLR: assert property (@(posedge clk) disable iff (rst)
        (eoi_spec_i && !take_i) |=> !isr_q[$past(eoi_lvl_i)]); // R10

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             addr_odd,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             ack,
    output logic [7:0]       ack_vector,
    output logic             int_out,
    output logic [2:0]       slave_id,
    output logic [7:0]       slave_map
);

    localparam int LVL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    logic [N_IRQ-1:0]      mask, irr, isr;
    logic [BYTE_W-1:LVL_W] base;
    byte_t                 casc;
    logic                  aeoi, ready, clr_all, eoi_spec, eoi_any;
    logic [LVL_W-1:0]      eoi_lvl, pend_lvl, svc_top, take_lvl;
    logic                  pend_valid, svc_any, raise, take;
    rb_sel_e               rb_sel;

    intc_prog #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_prog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr_odd(addr_odd), .wr_data(wr_data),
        .mask_o(mask), .base_o(base), .casc_o(casc), .aeoi_o(aeoi), .rb_sel_o(rb_sel),
        .ready_o(ready), .clr_all_o(clr_all), .eoi_spec_o(eoi_spec), .eoi_any_o(eoi_any),
        .eoi_lvl_o(eoi_lvl)
    );

    intc_resolve #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_resolve (
        .irr_i(irr), .isr_i(isr), .mask_i(mask),
        .pend_valid_o(pend_valid), .pend_lvl_o(pend_lvl),
        .svc_any_o(svc_any), .svc_top_o(svc_top), .raise_o(raise)
    );

    assign int_out  = ready && raise;
    assign take     = ack && int_out;
    assign take_lvl = take ? pend_lvl : LVL_W'(N_IRQ - 1);

    intc_track #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_track (
        .clk(clk), .rst(rst), .irq_i(irq_in), .clr_all_i(clr_all),
        .ack_i(ack), .take_i(take), .take_lvl_i(take_lvl), .aeoi_i(aeoi),
        .eoi_spec_i(eoi_spec), .eoi_any_i(eoi_any), .eoi_lvl_i(eoi_lvl),
        .svc_any_i(svc_any), .svc_top_i(svc_top),
        .irr_o(irr), .isr_o(isr)
    );

    assign ack_vector = {base, take_lvl};
    assign rd_data    = addr_odd           ? BYTE_W'(mask) :
                        (rb_sel == RB_SVC) ? BYTE_W'(isr)  : BYTE_W'(irr);
    assign slave_map  = casc;
    assign slave_id   = casc[2:0];

    AST_QUIET_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !int_out); // R2
    AST_SPUR_LEVEL7: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out) |-> ack_vector[LVL_W-1:0] == LVL_W'(N_IRQ - 1)); // R8
    AST_INT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (irr & ~mask) != '0); // R6

endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, addr_odd = 1'b0, ack = 1'b0;
    logic [7:0] wr_data = '0, irq_in = '0;
    logic [7:0] rd_data, ack_vector, slave_map;
    logic [2:0] slave_id;
    logic       int_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] vec;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr_odd(addr_odd), .wr_data(wr_data),
        .rd_data(rd_data), .irq_in(irq_in), .ack(ack), .ack_vector(ack_vector),
        .int_out(int_out), .slave_id(slave_id), .slave_map(slave_map)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic odd, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr_odd = odd; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr_odd = 1'b0;
        #1;
    endtask

    task automatic rd(input logic odd, input string req, input logic [7:0] exp);
        addr_odd = odd;
        #1;
        check(req, rd_data, exp);
        addr_odd = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] exp_vec, input string req);
        exp_t e;
        @(negedge clk);
        ack = 1'b1;
        e.vec = exp_vec; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        ack = 1'b0;
        #1;
    endtask

    task automatic pulse_line(input int n);
        @(negedge clk); irq_in[n] = 1'b0;
        @(negedge clk); irq_in[n] = 1'b1;
        @(negedge clk);
        #1;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (ack) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected ack", ack_vector, 8'hxx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, ack_vector, e.vec);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 int_out", {7'b0, int_out}, 8'h00);
        rd(1'b1, "R1 mask", 8'hFF);
        rd(1'b0, "R1 irr", 8'h00);

        // line 3 high before configuration, then configuration clears it
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); #1;
        check("R2 int before ready", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h11);
        rd(1'b0, "R2 start clears irr", 8'h00);
        wr(1'b1, 8'h40);
        check("R2 int mid config", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        check("R3 slave_map", slave_map, 8'h04);
        check("R3 slave_id", {5'b0, slave_id}, 8'h04);
        wr(1'b1, 8'h00);
        rd(1'b1, "R4 mask readback", 8'h00);
        check("R5 held line no relatch", {7'b0, int_out}, 8'h00);

        pulse_line(3);
        rd(1'b0, "R5 edge latched", 8'h08);
        check("R6 int raised", {7'b0, int_out}, 8'h01);
        wr(1'b1, 8'h08);
        check("R4 masked int low", {7'b0, int_out}, 8'h00);
        rd(1'b0, "R5 latched while masked", 8'h08);
        wr(1'b1, 8'h00);

        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk); #1;
        do_ack(8'h43, "R7 vector lvl3");
        rd(1'b0, "R7 irr after ack", 8'h20);
        check("R6 blocked by svc3", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R9 isr select", 8'h08);

        @(negedge clk); irq_in[1] = 1'b1;
        @(negedge clk); #1;
        check("R6 nesting int", {7'b0, int_out}, 8'h01);
        do_ack(8'h41, "R7 vector lvl1");
        rd(1'b0, "R9 select persists", 8'h0A);
        wr(1'b0, 8'h66);
        rd(1'b0, "R10 other bits kept", 8'h0A);
        wr(1'b0, 8'h20);
        rd(1'b0, "R11 nonspecific clears top", 8'h08);
        check("R6 still blocked", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h63);
        rd(1'b0, "R10 specific clear", 8'h00);
        check("R6 unblocked", {7'b0, int_out}, 8'h01);
        wr(1'b0, 8'h0A);
        rd(1'b0, "R9 irr select", 8'h20);
        do_ack(8'h45, "R7 vector lvl5");
        rd(1'b0, "R7 irr empty", 8'h00);

        do_ack(8'h47, "R8 spurious vector");
        wr(1'b0, 8'h0B);
        rd(1'b0, "R8 isr unchanged", 8'h20);
        wr(1'b0, 8'h65);
        rd(1'b0, "R10 clear lvl5", 8'h00);
        wr(1'b1, 8'h80);
        do_ack(8'h47, "R8 spurious masked7");
        rd(1'b0, "R8 isr still empty", 8'h00);

        // second configuration: single, mode word with automatic EOI
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h88);
        @(negedge clk); irq_in[2] = 1'b1;
        @(negedge clk); #1;
        check("R2 quiet before mode word", {7'b0, int_out}, 8'h00);
        rd(1'b0, "R2 readback back to irr", 8'h04);
        wr(1'b1, 8'h03);
        check("R3 casc kept", slave_map, 8'h04);
        check("R12 int ready", {7'b0, int_out}, 8'h01);
        do_ack(8'h8A, "R12 vector lvl2");
        wr(1'b0, 8'h0B);
        rd(1'b0, "R12 no isr", 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, "R12 irr cleared", 8'h00);

        @(negedge clk);
        check("R7 scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule